// File: doc/BRIEF.md
# USB Host Receive Babble Guard

This block sits on the receive side of a USB host channel, between the packet decoder and the receive FIFO. Each byte of an incoming IN packet is counted against the channel's maximum packet size. Bytes that fit are forwarded to the FIFO write port. Once a packet runs past the limit, the rest of its data is kept out of the FIFO, and the block waits for the end-of-packet marker. At that marker it rewinds the FIFO write pointer to the last committed position, so the packet leaves no trace in the FIFO. It then raises a sticky babble interrupt and halts the channel with a babble halt reason.

A second condition, called port babble, is data still arriving while the frame timer reports the late end-of-frame window, just before the next start-of-frame. This also aborts the packet with a rewind and halts the channel. It sets a separate status bit in addition to the interrupt. A packet that ends cleanly is committed: the committed pointer moves past its bytes, and the remaining transfer count drops by its length.

Software re-arms the channel with a one-cycle enable pulse, which loads the transfer size. For IN transfers, software programs that size as a whole multiple of the maximum packet size.

Top module: `usb_rx_babble_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the registered outputs read zero: `chan_active`, `halt_reason`, `intr_babble`, `stat_port_babble`, `xfer_remaining`, `fifo_wr_addr` and `fifo_commit_ptr`. `fifo_wr_en` is low.
- R2: A `ch_enable` pulse sets `chan_active`, clears `halt_reason` to 0 and loads `xfer_remaining` from `cfg_xfer_size` on the next cycle. While `chan_active` is low, received beats cause no FIFO write, rewind or commit, and no state change.
- R3: In an active channel, each received byte whose running count within the packet is at most `cfg_max_pkt` is written in the same cycle. It goes to `fifo_wr_addr` with `fifo_wr_data` equal to `rx_data`, and the address steps by one (modulo the FIFO depth) for the next byte. A beat with `rx_sop` set starts the count at 1.
- R4: Once a packet's byte count exceeds `cfg_max_pkt`, no further byte of that packet is written, although the stream is still consumed.
- R5: On the end-of-packet beat of a packet that exceeded the limit, `fifo_rewind` pulses in that cycle. On the next cycle, `fifo_wr_addr` equals `fifo_commit_ptr`, `intr_babble` is 1, `chan_active` is 0 and `halt_reason` is 1 (babble).
- R6: On the end-of-packet beat of a packet within the limit, `fifo_commit` pulses. On the next cycle, `fifo_commit_ptr` has advanced by the packet length and `xfer_remaining` has dropped by that length, saturating at 0. Neither value changes at any other time except on `ch_enable`.
- R7: A received beat while `frame_late` is high is not written. It pulses `fifo_rewind`, and on the next cycle sets `stat_port_babble` and `intr_babble`, clears `chan_active` and sets `halt_reason` to 1. It takes precedence over packet babble and over end-of-packet.
- R8: An `int_clr` pulse clears `intr_babble` and `stat_port_babble`. A babble event in the same cycle wins over the clear. `halt_reason` keeps its value until the next `ch_enable`.
- R9: A packet of exactly `cfg_max_pkt` bytes is written in full and committed, with no babble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | 1 | One-cycle channel (re)enable pulse |
| cfg_max_pkt | input | MPS_W | Maximum packet size in bytes |
| cfg_xfer_size | input | XFER_W | Transfer size loaded on enable |
| rx_valid | input | 1 | Data byte valid |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| rx_data | input | 8 | Received data byte |
| frame_late | input | 1 | Frame timer is in the late end-of-frame window |
| int_clr | input | 1 | Write-one-to-clear pulse for the sticky status bits |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_addr | output | PTR_W | FIFO write address |
| fifo_wr_data | output | 8 | FIFO write data |
| fifo_commit | output | 1 | Packet accepted pulse |
| fifo_rewind | output | 1 | Discard the uncommitted packet pulse |
| fifo_commit_ptr | output | PTR_W | Committed FIFO write position |
| chan_active | output | 1 | Channel enabled and not halted |
| halt_reason | output | 2 | 0 none, 1 babble |
| intr_babble | output | 1 | Sticky babble interrupt |
| stat_port_babble | output | 1 | Sticky end-of-frame babble flag |
| xfer_remaining | output | XFER_W | Bytes left in the transfer |

## Verification
A behavioural model tracks the counts, the pointers and the sticky bits. It is stepped with packets shorter than the limit, exactly at the limit and past the limit, so that clean commit can be told apart from packet babble at the boundary. It also sees a single-byte packet, an idle gap inside a packet, and traffic into a late end-of-frame window, which separates port babble from packet babble by its extra status bit. Beats sent while the channel is halted or not yet enabled, a clear pulse in the same cycle as a babble event, and a short transfer size check the input filtering, the set-over-clear priority and the saturation of the remaining count.

// File: rtl/babble_pkg.sv
package babble_pkg;
    localparam int DEF_MPS_W  = 11;
    localparam int DEF_PTR_W  = 6;
    localparam int DEF_XFER_W = 19;

    typedef enum logic [1:0] {
        HALT_NONE   = 2'd0,
        HALT_BABBLE = 2'd1
    } halt_e;

    // per-beat decisions taken by the top from counter and frame state
    typedef struct packed {
        logic beat;
        logic write;
        logic good_eop;
        logic pkt_babble;
        logic port_babble;
    } rx_evt_t;

    function automatic logic sat_above(input logic [15:0] cnt, input logic [15:0] lim);
        return cnt > lim;
    endfunction
endpackage

// File: rtl/babble_byte_counter.sv
module babble_byte_counter #(
    parameter int MPS_W = babble_pkg::DEF_MPS_W,
    localparam int CNT_W = MPS_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             beat,
    input  logic             sop,
    input  logic             end_pkt,
    input  logic [MPS_W-1:0] max_pkt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             over_nxt
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] lim;

    assign lim  = {1'b0, max_pkt};
    assign base = sop ? '0 : cnt_q;
    // saturate one above the limit so the overflow state stays put
    assign cnt_nxt  = (base > lim) ? base : base + 1'b1;
    assign over_nxt = cnt_nxt > lim;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= end_pkt ? '0 : cnt_nxt;
        end
    end

    // R4: an overflowed packet stays overflowed until it ends
    assert_over_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        (beat && !sop && !end_pkt && !clr && over_nxt) |=> (cnt_q > {1'b0, $past(max_pkt)}));
endmodule

// File: rtl/rx_fifo_ptrs.sv
module rx_fifo_ptrs #(
    parameter int PTR_W = babble_pkg::DEF_PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             write,
    input  logic             commit,
    input  logic             rewind,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] commit_ptr
);
    logic [PTR_W-1:0] wr_inc;
    assign wr_inc = wr_ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            commit_ptr <= '0;
        end else if (rewind) begin
            wr_ptr <= commit_ptr;
        end else begin
            if (write) wr_ptr <= wr_inc;
            if (commit) commit_ptr <= write ? wr_inc : wr_ptr;
        end
    end

    // R5: a rewind leaves the write pointer on the committed position
    assert_rewind_home_R5: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (wr_ptr == commit_ptr));
    // R6: the committed pointer moves only on commit
    assert_commit_only_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(commit_ptr));
endmodule

// File: rtl/babble_status.sv
module babble_status
    import babble_pkg::*;
#(
    parameter int XFER_W = DEF_XFER_W,
    parameter int CNT_W  = DEF_MPS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_enable,
    input  logic [XFER_W-1:0] cfg_xfer,
    input  logic              int_clr,
    input  rx_evt_t           evt,
    input  logic [CNT_W-1:0]  pkt_len,
    output logic              active,
    output halt_e             reason,
    output logic              intr,
    output logic              port_flag,
    output logic [XFER_W-1:0] remaining
);
    logic              any_babble;
    logic [XFER_W-1:0] len_ext;

    assign any_babble = evt.pkt_babble | evt.port_babble;
    assign len_ext    = XFER_W'(pkt_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            reason    <= HALT_NONE;
            intr      <= 1'b0;
            port_flag <= 1'b0;
            remaining <= '0;
        end else begin
            if (ch_enable) begin
                active    <= 1'b1;
                reason    <= HALT_NONE;
                remaining <= cfg_xfer;
            end else begin
                if (any_babble) begin
                    active <= 1'b0;
                    reason <= HALT_BABBLE;
                end
                if (evt.good_eop) begin
                    remaining <= (remaining > len_ext) ? remaining - len_ext : '0;
                end
            end
            // sticky bits: set beats clear
            if (any_babble) intr <= 1'b1;
            else if (int_clr) intr <= 1'b0;
            if (evt.port_babble) port_flag <= 1'b1;
            else if (int_clr) port_flag <= 1'b0;
        end
    end

    assert_halt_on_babble_R5: assert property (@(posedge clk) disable iff (rst)
        (any_babble && !ch_enable) |=> (!active && reason == HALT_BABBLE && intr));
    assert_port_flag_R7: assert property (@(posedge clk) disable iff (rst)
        evt.port_babble |=> port_flag);
    assert_remaining_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!evt.good_eop && !ch_enable) |=> $stable(remaining));
    assert_reason_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ch_enable && reason == HALT_BABBLE) |=> (reason == HALT_BABBLE));
endmodule

// File: rtl/usb_rx_babble_guard.sv
module usb_rx_babble_guard
    import babble_pkg::*;
#(
    parameter int MPS_W  = DEF_MPS_W,
    parameter int PTR_W  = DEF_PTR_W,
    parameter int XFER_W = DEF_XFER_W,
    localparam int CNT_W = MPS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_enable,
    input  logic [MPS_W-1:0]  cfg_max_pkt,
    input  logic [XFER_W-1:0] cfg_xfer_size,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_data,
    input  logic              frame_late,
    input  logic              int_clr,
    output logic              fifo_wr_en,
    output logic [PTR_W-1:0]  fifo_wr_addr,
    output logic [7:0]        fifo_wr_data,
    output logic              fifo_commit,
    output logic              fifo_rewind,
    output logic [PTR_W-1:0]  fifo_commit_ptr,
    output logic              chan_active,
    output logic [1:0]        halt_reason,
    output logic              intr_babble,
    output logic              stat_port_babble,
    output logic [XFER_W-1:0] xfer_remaining
);
    rx_evt_t          evt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             over_nxt;
    halt_e            reason;

    always_comb begin
        evt.beat        = rx_valid & chan_active;
        evt.port_babble = evt.beat & frame_late;
        evt.write       = evt.beat & ~frame_late & ~over_nxt;
        evt.good_eop    = evt.write & rx_eop;
        evt.pkt_babble  = evt.beat & ~frame_late & over_nxt & rx_eop;
    end

    babble_byte_counter #(.MPS_W(MPS_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (ch_enable),
        .beat    (evt.beat),
        .sop     (rx_sop),
        .end_pkt (rx_eop | frame_late),
        .max_pkt (cfg_max_pkt),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .over_nxt(over_nxt)
    );

    rx_fifo_ptrs #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .write     (evt.write),
        .commit    (evt.good_eop),
        .rewind    (fifo_rewind),
        .wr_ptr    (fifo_wr_addr),
        .commit_ptr(fifo_commit_ptr)
    );

    babble_status #(.XFER_W(XFER_W), .CNT_W(CNT_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .ch_enable(ch_enable),
        .cfg_xfer (cfg_xfer_size),
        .int_clr  (int_clr),
        .evt      (evt),
        .pkt_len  (cnt_nxt),
        .active   (chan_active),
        .reason   (reason),
        .intr     (intr_babble),
        .port_flag(stat_port_babble),
        .remaining(xfer_remaining)
    );

    assign halt_reason  = reason;
    assign fifo_wr_en   = evt.write;
    assign fifo_wr_data = rx_data;
    assign fifo_commit  = evt.good_eop;
    assign fifo_rewind  = evt.pkt_babble | evt.port_babble;

    // R4: a packet already past the limit writes nothing more
    assert_drop_after_over_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_sop && cnt_q > {1'b0, cfg_max_pkt}) |-> !fifo_wr_en);
    // R7: a late-window beat is never written
    assert_late_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        frame_late |-> !fifo_wr_en);
endmodule

// File: tb/tb_usb_rx_babble_guard.sv
module tb_usb_rx_babble_guard;
    localparam int MPS_W = 11, PTR_W = 6, XFER_W = 19;
    localparam int DEPTH = 1 << PTR_W;
    localparam int MAXP  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ch_enable = 0, rx_valid = 0, rx_sop = 0, rx_eop = 0, frame_late = 0, int_clr = 0;
    logic [MPS_W-1:0]  cfg_max_pkt = MPS_W'(MAXP);
    logic [XFER_W-1:0] cfg_xfer_size = '0;
    logic [7:0]        rx_data = '0;
    logic              fifo_wr_en, fifo_commit, fifo_rewind, chan_active;
    logic              intr_babble, stat_port_babble;
    logic [PTR_W-1:0]  fifo_wr_addr, fifo_commit_ptr;
    logic [7:0]        fifo_wr_data;
    logic [1:0]        halt_reason;
    logic [XFER_W-1:0] xfer_remaining;

    always #4 clk = ~clk;

    usb_rx_babble_guard #(.MPS_W(MPS_W), .PTR_W(PTR_W), .XFER_W(XFER_W)) dut (
        .clk(clk), .rst(rst), .ch_enable(ch_enable), .cfg_max_pkt(cfg_max_pkt),
        .cfg_xfer_size(cfg_xfer_size), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_data(rx_data), .frame_late(frame_late), .int_clr(int_clr),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_addr(fifo_wr_addr), .fifo_wr_data(fifo_wr_data),
        .fifo_commit(fifo_commit), .fifo_rewind(fifo_rewind),
        .fifo_commit_ptr(fifo_commit_ptr), .chan_active(chan_active),
        .halt_reason(halt_reason), .intr_babble(intr_babble),
        .stat_port_babble(stat_port_babble), .xfer_remaining(xfer_remaining)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    // reference model state
    int m_act = 0, m_cnt = 0, m_wr = 0, m_cm = 0, m_rem = 0, m_intr = 0, m_port = 0, m_rsn = 0;

    task automatic chk(input string tag, input string sig, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // one clock: inputs are already driven; compare mid-cycle, then advance model
    task automatic cyc(input string tag);
        int beat, cn, over, pb, wr, good, bab;
        #2;
        beat = (rx_valid && m_act) ? 1 : 0;
        cn   = rx_sop ? 1 : m_cnt + 1;
        if (cn > MAXP + 1) cn = MAXP + 1;
        over = (cn > MAXP) ? 1 : 0;
        pb   = (beat && frame_late) ? 1 : 0;
        wr   = (beat && !pb && !over) ? 1 : 0;
        good = (wr && rx_eop) ? 1 : 0;
        bab  = (beat && !pb && over && rx_eop) ? 1 : 0;
        if (rst) begin wr = 0; good = 0; bab = 0; pb = 0; end
        chk(tag, "wr_en", int'(fifo_wr_en), wr);
        if (wr != 0) chk(tag, "wr_data", int'(fifo_wr_data), int'(rx_data));
        chk(tag, "wr_addr", int'(fifo_wr_addr), m_wr);
        chk(tag, "commit", int'(fifo_commit), good);
        chk(tag, "rewind", int'(fifo_rewind), (bab || pb) ? 1 : 0);
        chk(tag, "commit_ptr", int'(fifo_commit_ptr), m_cm);
        chk(tag, "active", int'(chan_active), m_act);
        chk(tag, "halt_reason", int'(halt_reason), m_rsn);
        chk(tag, "intr", int'(intr_babble), m_intr);
        chk(tag, "port_flag", int'(stat_port_babble), m_port);
        chk(tag, "remaining", int'(xfer_remaining), m_rem);
        if (rst) begin
            m_act = 0; m_cnt = 0; m_wr = 0; m_cm = 0; m_rem = 0; m_intr = 0; m_port = 0; m_rsn = 0;
        end else begin
            if (beat != 0) m_cnt = (rx_eop || frame_late) ? 0 : cn;
            if (bab || pb) m_wr = m_cm;
            else if (wr != 0) begin
                m_wr = (m_wr + 1) % DEPTH;
                if (good != 0) m_cm = m_wr;
            end
            if (ch_enable) begin
                m_act = 1; m_rsn = 0; m_rem = int'(cfg_xfer_size); m_cnt = 0;
            end else begin
                if (bab || pb) begin m_act = 0; m_rsn = 1; end
                if (good != 0) m_rem = (m_rem > cn) ? m_rem - cn : 0;
            end
            if (bab || pb) m_intr = 1; else if (int_clr) m_intr = 0;
            if (pb != 0) m_port = 1; else if (int_clr) m_port = 0;
        end
        @(negedge clk);
        ch_enable = 0; int_clr = 0; rx_valid = 0; rx_sop = 0; rx_eop = 0; frame_late = 0;
    endtask

    task automatic enable(input int xfer, input string tag);
        cfg_xfer_size = XFER_W'(xfer);
        ch_enable = 1;
        cyc(tag);
    endtask

    // n bytes; late_at >= 0 raises frame_late on that byte; gap_at inserts an idle cycle
    task automatic pkt(input int n, input int late_at, input int gap_at,
                       input bit clr_eop, input string tag);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) cyc(tag);
            rx_valid = 1; rx_sop = (i == 0); rx_eop = (i == n - 1);
            rx_data = 8'(8'hA0 + i);
            frame_late = (i == late_at);
            int_clr = clr_eop && (i == n - 1);
            cyc(tag);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin rst = 1; cyc("R1"); end
        rst = 0;
        cyc("R1");
        pkt(3, -1, -1, 0, "R2");         // ignored while not enabled
        enable(40, "R2");
        cyc("R2");
        pkt(5, -1, 2, 0, "R3");          // good packet with an idle gap
        pkt(1, -1, -1, 0, "R6");         // single-byte packet
        pkt(MAXP, -1, -1, 0, "R9");      // exactly the limit
        pkt(MAXP + 3, -1, -1, 0, "R4");  // packet babble
        cyc("R5");
        pkt(4, -1, -1, 0, "R2");         // halted: ignored
        int_clr = 1; cyc("R8");
        cyc("R8");
        enable(40, "R8");
        pkt(6, 3, -1, 0, "R7");          // port babble mid-packet
        pkt(2, -1, -1, 0, "R7");         // remainder ignored while halted
        cyc("R7");
        enable(64, "R2");
        pkt(MAXP + 1, -1, -1, 1, "R8");  // clear in the babble cycle: set wins
        cyc("R8");
        int_clr = 1; cyc("R8");
        enable(3, "R6");
        pkt(5, -1, -1, 0, "R6");         // remaining saturates at zero
        pkt(MAXP, MAXP - 1, -1, 0, "R7"); // late on the end-of-packet beat
        cyc("R7");
        for (int i = 0; i < 2; i++) cyc("R8");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule